// File: doc/BRIEF.md
# Reset and Stop-Recovery Sequencer

This block decides when a small chip may run after power-up, after a brown-out and after a low-power stop. One counter, `CNT_W` bits wide, runs on the oscillator clock and serves three purposes. It times the oscillator settling period that comes before the bus clocks start. It sets the wait from a stop wake-up to the return of the bus clocks. Its overflow is also the prescaled tick that drives the watchdog. The integrator connects the inverted oscillator to `clk_osc`, so the counter advances on the oscillator's falling edge.

After a reset is removed, the bus clocks return once the counter has passed its full span. The CPU is then held for a further `RST_EXTRA` cycles before it is released. A stop request in the running state gates the bus clocks and clears the counter. A wake event then starts a recovery of either `SHORT_WAKE` cycles or the full counter span, chosen by a configuration bit. A low-voltage trip reaches the logic through a two-flop synchronizer. It resets the chip only when both of its disable bits are low. A status register records whether the last reset came from power-on or from low voltage, and a read strobe clears it.

`por_i` is the power-on request and also serves as the block's synchronous active-high reset.

Top module: `rst_recovery_seq`

## Requirements
- R1: While `por_i` is high, `chip_rst_o`=1, `bus_clk_en_o`=0, `cpu_release_o`=0, `wdog_tick_o`=0 and `rst_cause_o`=2'b01.
- R2: The first rising edge that samples `por_i` low counts as edge 1 (with no low-voltage reset present). `bus_clk_en_o` becomes 1 after edge 4097, which is 2^CNT_W settling cycles plus one cycle to leave hold. `chip_rst_o` is still 1 at that point.
- R3: 64 edges after `bus_clk_en_o` rises, `chip_rst_o` falls and `cpu_release_o` is 1 for exactly one cycle.
- R4: `wdog_tick_o` is a one-cycle pulse, raised once each time the counter wraps. In the running state the pulses are 4096 cycles apart.
- R5: In the running state, `stop_req_i` sampled high drops `bus_clk_en_o` at that edge and clears and holds the counter, so no tick appears while stopped. In any other state `stop_req_i` is ignored.
- R6: The edge that samples `wake_i` high in stop counts as edge 1. `bus_clk_en_o` returns after edge 33 when `cfg_short_wake_i` was 1 at that edge, and after edge 4097 when it was 0.
- R7: The counter restarts from zero at stop. After a short wake, the first tick therefore comes 4064 cycles after `bus_clk_en_o` returns.
- R8: With both `cfg_lv_pwrdn_dis_i` and `cfg_lv_rst_dis_i` low, a synchronized `lv_trip_i` forces `chip_rst_o`=1 and `bus_clk_en_o`=0 and sets `rst_cause_o[1]`. The block stays in reset while the trip lasts. The first edge that samples the trip low counts as edge 1, and `bus_clk_en_o` rises after edge 4099.
- R9: If either disable bit is 1, `lv_trip_i` has no effect: no reset, `bus_clk_en_o` stays 1 and `rst_cause_o[1]` stays 0.
- R10: `rst_cause_o` bit 0 marks power-on and bit 1 marks low voltage. Power-on sets bit 0 and clears bit 1. `stat_rd_i` sampled high clears both bits, except that a low-voltage set in the same cycle wins.
- R11: `por_i` asserted during a stop recovery aborts it. The full sequence of R2 and R3 then restarts from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock (inverted oscillator) |
| por_i | input | 1 | Power-on request, synchronous active-high reset |
| lv_trip_i | input | 1 | Asynchronous low-voltage trip |
| cfg_lv_pwrdn_dis_i | input | 1 | Low-voltage power-down disable |
| cfg_lv_rst_dis_i | input | 1 | Low-voltage reset disable |
| cfg_short_wake_i | input | 1 | 1 selects the short stop recovery |
| stop_req_i | input | 1 | Enter stop mode |
| wake_i | input | 1 | Wake event while stopped |
| stat_rd_i | input | 1 | Status read strobe, clears cause bits |
| bus_clk_en_o | output | 1 | Internal bus clock enable |
| chip_rst_o | output | 1 | Chip reset |
| cpu_release_o | output | 1 | One-cycle CPU release pulse |
| wdog_tick_o | output | 1 | Watchdog prescaler tick |
| rst_cause_o | output | 2 | Sticky reset cause bits {low-voltage, power-on} |

## Verification
A counter that is off by any amount shows up as a wrong count of edges, either before `bus_clk_en_o` returns or between ticks. The recovery checks count each delay exactly rather than against a bound, so one cycle of error is seen within a single recovery. A counter left uncleared at stop cannot be seen in the wake delay alone. It moves the first tick after wake, and that shift appears within 4096 cycles. A state machine stuck in the wrong state shows at once on `chip_rst_o` or `bus_clk_en_o`. Missing set or clear logic shows on `rst_cause_o` at the next read.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    typedef enum logic [2:0] {
        SQ_HOLD,   // held in reset, counter cleared
        SQ_OSC,    // oscillator settling
        SQ_CPU,    // bus clocks on, CPU still held
        SQ_RUN,    // normal operation, counter free-running
        SQ_STOP,   // stopped, counter cleared and held
        SQ_WAKE    // stop recovery delay
    } seq_state_e;

    typedef struct packed {
        logic lv;
        logic por;
    } cause_t;

    function automatic logic counts_in(seq_state_e s);
        return s inside {SQ_OSC, SQ_CPU, SQ_RUN, SQ_WAKE};
    endfunction

    function automatic logic bus_on_in(seq_state_e s);
        return s inside {SQ_CPU, SQ_RUN};
    endfunction

    function automatic logic reset_in(seq_state_e s);
        return s inside {SQ_HOLD, SQ_OSC, SQ_CPU};
    endfunction

endpackage

// File: rtl/rrs_sync.sv
module rrs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh[STAGES-1];
endmodule

// File: rtl/rrs_counter.sv
module rrs_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap_tick
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            wrap_tick <= 1'b0;
        end else begin
            wrap_tick <= run && !clr && (cnt == CNT_MAX);
            if (clr)      cnt <= '0;
            else if (run) cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/rrs_ctrl.sv
module rrs_ctrl
    import rrs_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int RST_EXTRA  = 64,
    parameter int SHORT_WAKE = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lv_rst,
    input  logic             stop_req,
    input  logic             wake,
    input  logic             short_sel,
    input  logic [CNT_W-1:0] cnt,
    output seq_state_e       state,
    output logic             cnt_clr,
    output logic             cnt_run,
    output logic             release_q,
    output logic             wake_done_q
);
    localparam logic [CNT_W-1:0] SPAN_LAST  = '1;
    localparam logic [CNT_W-1:0] EXTRA_LAST = CNT_W'(RST_EXTRA - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_WAKE - 1);

    seq_state_e       nxt;
    logic             rel_c, done_c;
    logic [CNT_W-1:0] wake_last_q;

    always_comb begin
        nxt     = state;
        cnt_clr = 1'b0;
        rel_c   = 1'b0;
        done_c  = 1'b0;
        if (lv_rst) begin
            nxt     = SQ_HOLD;
            cnt_clr = 1'b1;
        end else begin
            case (state)
                SQ_HOLD: begin
                    nxt     = SQ_OSC;
                    cnt_clr = 1'b1;
                end
                SQ_OSC:  if (cnt == SPAN_LAST) nxt = SQ_CPU;
                SQ_CPU:  if (cnt == EXTRA_LAST) begin
                    nxt   = SQ_RUN;
                    rel_c = 1'b1;
                end
                SQ_RUN:  if (stop_req) begin
                    nxt     = SQ_STOP;
                    cnt_clr = 1'b1;
                end
                SQ_STOP: begin
                    cnt_clr = 1'b1;
                    if (wake) nxt = SQ_WAKE;
                end
                SQ_WAKE: if (cnt == wake_last_q) begin
                    nxt    = SQ_RUN;
                    done_c = 1'b1;
                end
                default: begin
                    nxt     = SQ_HOLD;
                    cnt_clr = 1'b1;
                end
            endcase
        end
    end

    assign cnt_run = counts_in(state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= SQ_HOLD;
            release_q   <= 1'b0;
            wake_done_q <= 1'b0;
            wake_last_q <= SPAN_LAST;
        end else begin
            state       <= nxt;
            release_q   <= rel_c;
            wake_done_q <= done_c;
            if (state == SQ_STOP && wake && !lv_rst)
                wake_last_q <= short_sel ? SHORT_LAST : SPAN_LAST;
        end
    end
endmodule

// File: rtl/rrs_status.sv
module rrs_status
    import rrs_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   lv_set,
    input  logic   rd_clr,
    output cause_t cause
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cause.por <= 1'b1;
            cause.lv  <= 1'b0;
        end else begin
            cause.por <= cause.por && !rd_clr;
            cause.lv  <= lv_set || (cause.lv && !rd_clr);
        end
    end
endmodule

// File: rtl/rst_recovery_seq.sv
module rst_recovery_seq
    import rrs_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int RST_EXTRA   = 64,
    parameter int SHORT_WAKE  = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_osc,
    input  logic       por_i,
    input  logic       lv_trip_i,
    input  logic       cfg_lv_pwrdn_dis_i,
    input  logic       cfg_lv_rst_dis_i,
    input  logic       cfg_short_wake_i,
    input  logic       stop_req_i,
    input  logic       wake_i,
    input  logic       stat_rd_i,
    output logic       bus_clk_en_o,
    output logic       chip_rst_o,
    output logic       cpu_release_o,
    output logic       wdog_tick_o,
    output logic [1:0] rst_cause_o
);
    logic             lv_sync;
    logic             lv_rst;
    logic [CNT_W-1:0] cnt;
    logic             cnt_clr, cnt_run;
    logic             wake_done;
    seq_state_e       state;
    cause_t           cause;

    rrs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk_osc), .rst(por_i), .d(lv_trip_i), .q(lv_sync)
    );

    assign lv_rst = lv_sync && !cfg_lv_pwrdn_dis_i && !cfg_lv_rst_dis_i;

    rrs_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk_osc), .rst(por_i), .clr(cnt_clr), .run(cnt_run),
        .cnt(cnt), .wrap_tick(wdog_tick_o)
    );

    rrs_ctrl #(.CNT_W(CNT_W), .RST_EXTRA(RST_EXTRA), .SHORT_WAKE(SHORT_WAKE)) u_ctrl (
        .clk(clk_osc), .rst(por_i), .lv_rst(lv_rst), .stop_req(stop_req_i),
        .wake(wake_i), .short_sel(cfg_short_wake_i), .cnt(cnt),
        .state(state), .cnt_clr(cnt_clr), .cnt_run(cnt_run),
        .release_q(cpu_release_o), .wake_done_q(wake_done)
    );

    rrs_status u_stat (
        .clk(clk_osc), .rst(por_i), .lv_set(lv_rst), .rd_clr(stat_rd_i), .cause(cause)
    );

    assign bus_clk_en_o = bus_on_in(state);
    assign chip_rst_o   = reset_in(state);
    assign rst_cause_o  = cause;
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker (
    input logic       clk,
    input logic       rst,
    input logic       lv_rst,
    input logic       stop_req,
    input logic       stat_rd,
    input logic       wake_done,
    input logic       bus_clk_en,
    input logic       chip_rst,
    input logic       cpu_release,
    input logic       wdog_tick,
    input logic [1:0] rst_cause
);
    // R8: a qualified low-voltage condition holds the chip in reset
    a_r8_lv_forces_reset: assert property (@(posedge clk) disable iff (rst)
        lv_rst |=> (chip_rst && !bus_clk_en));

    // R3: release is a single-cycle pulse
    a_r3_release_single: assert property (@(posedge clk) disable iff (rst)
        cpu_release |=> !cpu_release);

    // R3: release follows a cycle spent in reset and leaves reset low
    a_r3_release_after_reset: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_release) |-> ($past(chip_rst) && !chip_rst));

    // R4: watchdog tick is one cycle wide
    a_r4_tick_single: assert property (@(posedge clk) disable iff (rst)
        wdog_tick |=> !wdog_tick);

    // R5: bus clocks drop only for a stop or a low-voltage reset
    a_r5_bus_drop_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_clk_en) |-> ($past(stop_req) || $past(lv_rst)));

    // R6: the end of a stop recovery coincides with running bus clocks
    a_r6_wake_done_enables: assert property (@(posedge clk) disable iff (rst)
        wake_done |-> (bus_clk_en && !chip_rst));

    // R10: a status read with no new cause leaves the register empty
    a_r10_read_clears: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !lv_rst) |=> (rst_cause == 2'b00));
endmodule

bind rst_recovery_seq rrs_checker u_chk (
    .clk(clk_osc), .rst(por_i), .lv_rst(lv_rst), .stop_req(stop_req_i),
    .stat_rd(stat_rd_i), .wake_done(wake_done), .bus_clk_en(bus_clk_en_o),
    .chip_rst(chip_rst_o), .cpu_release(cpu_release_o),
    .wdog_tick(wdog_tick_o), .rst_cause(rst_cause_o)
);

// File: tb/rst_recovery_seq_tb_top.sv
module rst_recovery_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 20000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       por, lv, pd_dis, rst_dis, short_sel, stop_req, wake, stat_rd;
    logic       bus_en, chip_rst, cpu_rel, tick;
    logic [1:0] cause;

    int n_chk  = 0;
    int n_fail = 0;

    rst_recovery_seq dut_i (
        .clk_osc(clk), .por_i(por), .lv_trip_i(lv),
        .cfg_lv_pwrdn_dis_i(pd_dis), .cfg_lv_rst_dis_i(rst_dis),
        .cfg_short_wake_i(short_sel), .stop_req_i(stop_req), .wake_i(wake),
        .stat_rd_i(stat_rd), .bus_clk_en_o(bus_en), .chip_rst_o(chip_rst),
        .cpu_release_o(cpu_rel), .wdog_tick_o(tick), .rst_cause_o(cause)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_bus(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!bus_en && n < LIMIT);
    endtask

    task automatic wait_rel(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!cpu_rel && n < LIMIT);
    endtask

    task automatic wait_tick(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!tick && n < LIMIT);
    endtask

    task automatic t_reset_state;
        por = 1'b1;
        cyc(3);
        chk("R1 chip_rst", chip_rst, 1);
        chk("R1 bus_clk_en", bus_en, 0);
        chk("R1 cpu_release", cpu_rel, 0);
        chk("R1 wdog_tick", tick, 0);
        chk("R1 cause", cause, 1);
    endtask

    task automatic t_power_on;
        int n;
        por = 1'b0;
        wait_bus(n);
        chk("R2 edges to bus enable", n, 4097);
        chk("R2 chip_rst while cpu held", chip_rst, 1);
        wait_rel(n);
        chk("R3 edges to cpu release", n, 64);
        chk("R3 chip_rst at release", chip_rst, 0);
        cyc(1);
        chk("R3 release width", cpu_rel, 0);
        chk("R10 power-on cause", cause, 1);
    endtask

    task automatic t_status_read;
        stat_rd = 1'b1;
        cyc(1);
        stat_rd = 1'b0;
        chk("R10 read clears", cause, 0);
    endtask

    task automatic t_tick;
        int n;
        wait_tick(n);
        wait_tick(n);
        chk("R4 tick spacing", n, 4096);
        cyc(1);
        chk("R4 tick width", tick, 0);
    endtask

    task automatic t_lv_masked;
        rst_dis = 1'b1;
        lv      = 1'b1;
        cyc(10);
        chk("R9 rst_dis chip_rst", chip_rst, 0);
        chk("R9 rst_dis bus", bus_en, 1);
        rst_dis = 1'b0;
        pd_dis  = 1'b1;
        cyc(10);
        chk("R9 pd_dis chip_rst", chip_rst, 0);
        chk("R9 pd_dis cause", cause, 0);
        lv = 1'b0;
        cyc(4);
        pd_dis = 1'b0;
        cyc(1);
    endtask

    task automatic t_stop(input logic sel, input int exp_wake);
        int n, ticks;
        stop_req = 1'b1;
        cyc(1);
        stop_req = 1'b0;
        chk("R5 bus off in stop", bus_en, 0);
        ticks = 0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (tick) ticks++;
        end
        chk("R5 no tick while stopped", ticks, 0);
        short_sel = sel;
        wake      = 1'b1;
        @(negedge clk);
        wake      = 1'b0;
        short_sel = ~sel;
        n = 1;
        while (!bus_en && n < LIMIT) begin @(negedge clk); n++; end
        chk(sel ? "R6 short wake edges" : "R6 long wake edges", n, exp_wake);
        if (sel) begin
            wait_tick(n);
            chk("R7 tick after short wake", n, 4064);
        end
    endtask

    task automatic t_lv_reset;
        int n;
        lv = 1'b1;
        cyc(5);
        chk("R8 chip_rst on trip", chip_rst, 1);
        chk("R8 bus off on trip", bus_en, 0);
        chk("R8 cause", cause, 2);
        cyc(30);
        chk("R8 held during trip", chip_rst, 1);
        lv = 1'b0;
        wait_bus(n);
        chk("R8 edges to bus after trip", n, 4099);
        wait_rel(n);
        chk("R8 release after trip", n, 64);
        t_status_read();
    endtask

    task automatic t_por_abort;
        int n;
        stop_req = 1'b1;
        cyc(1);
        stop_req  = 1'b0;
        cyc(3);
        short_sel = 1'b0;
        wake      = 1'b1;
        cyc(1);
        wake = 1'b0;
        cyc(100);
        por = 1'b1;
        cyc(2);
        chk("R11 chip_rst on abort", chip_rst, 1);
        chk("R11 bus off on abort", bus_en, 0);
        chk("R11 cause", cause, 1);
        por = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            stop_req = (n == 10);
        end while (!bus_en && n < LIMIT);
        stop_req = 1'b0;
        chk("R11 R5 restart edges with stop ignored", n, 4097);
        wait_rel(n);
        chk("R11 release after restart", n, 64);
    endtask

    initial begin
        lv = 0; pd_dis = 0; rst_dis = 0; short_sel = 0;
        stop_req = 0; wake = 0; stat_rd = 0; por = 1;
        @(negedge clk);
        t_reset_state();
        t_power_on();
        t_status_read();
        t_tick();
        t_lv_masked();
        t_stop(1'b1, 33);
        t_stop(1'b0, 4097);
        t_lv_reset();
        t_por_abort();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule